// File: doc/BRIEF.md
# Divided-Clock Countdown Timer with Interrupt Vector

This block is a per-processor countdown timer reached through four 32-bit word registers on a simple single-cycle bus. Software selects a clock divisor, gives a vector entry that holds the interrupt vector and the mode and mask bits, and then writes a start count. The timer then decrements once per divided clock period. When the count runs out, the timer sends a one-cycle request that carries the programmed vector.

In periodic mode the timer reloads the start count when it runs out and keeps counting. In one-shot mode it stops and returns to idle. Reading the current-count register gives the number of divided periods still remaining, rounded up, so a count that is partly used up still reads as a whole period.

The control is a two-state machine. In ST_IDLE the counter is zero. In ST_RUN the counter counts down. The transitions are as follows. *arm* goes from ST_IDLE to ST_RUN on a write of a non-zero start count. *restart* stays in ST_RUN when a new non-zero start count is written. *reload* stays in ST_RUN when the count expires in periodic mode. *expire* goes from ST_RUN to ST_IDLE when the count expires in one-shot mode. *stop* goes from ST_RUN to ST_IDLE on a write of a zero start count.

Top module: `cdtimer`

## Requirements
- R1: After reset, the registers read as follows: divide 0, start count 0, current count 0, vector entry 0x0001_0000 (masked). No request is raised.
- R2: Word addresses are 0 for divide, 1 for start count, 2 for current count and 3 for vector entry. The divide code is {divide[3], divide[1:0]}, and the divisor is 2^((code+1) mod 8). Code 3'b111 gives 1 and code 3'b000 gives 2. A request appears N×divisor clock edges after the edge that writes start count N.
- R3: The divide register keeps only bits 3, 1 and 0. All other bits read as zero.
- R4: Writing a start count restarts the countdown from that value and abandons any countdown already in progress. The current count reads the remaining time divided by the divisor, rounded up. It reads N right after the write.
- R5: The current count reads 0 in ST_IDLE. Bus writes to word address 2 have no effect.
- R6: Writing a start count of 0 stops the timer, and no request follows.
- R7: With entry bit 17 clear (one-shot mode), exactly one request is raised. The timer then returns to idle with a current count of 0.
- R8: With entry bit 17 set (periodic mode), the start count is reloaded on expiry, and a request comes every N×divisor edges.
- R9: With entry bit 16 set, the request is suppressed, but the countdown continues.
- R10: A request is `irq_pulse` high for one cycle. During that cycle, `irq_vec` holds entry bits 7:0.
- R11: Writes cannot change entry bits 12 and 14, which stay 0. Every other entry bit, and the start count, read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on bus_addr) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Vector that comes with the request |

## Verification
The assertions check the following on every cycle:
- The count is zero whenever the machine is idle.
- The count does not move between divided ticks unless it is loaded.
- A request follows only a tick taken at a count of one with the mask bit clear.
- Entry bits 12 and 14 never change.

Only the bench scenarios can show that expiry lands on the exact edge for each divide code, that periodic requests repeat on schedule, that a restart abandons the earlier countdown, and that the rounded-up value reads correctly in the middle of a divided period.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_RUN} cdt_state_e;

    localparam logic [1:0] REG_DIV   = 2'd0;
    localparam logic [1:0] REG_INIT  = 2'd1;
    localparam logic [1:0] REG_CUR   = 2'd2;
    localparam logic [1:0] REG_ENTRY = 2'd3;

    localparam int ENTRY_MASK_BIT     = 16;
    localparam int ENTRY_PERIODIC_BIT = 17;
    localparam logic [31:0] ENTRY_RO    = 32'h0000_5000;
    localparam logic [31:0] ENTRY_RESET = 32'h0001_0000;

    // divisor exponent: code {c[3],c[1:0]} plus one, wrapping modulo 8
    function automatic logic [2:0] div_shift(input logic [3:0] conf);
        logic [2:0] code;
        code = {conf[3], conf[1:0]};
        return code + 3'd1;
    endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [31:0]   wdata,
    output logic [3:0]    div_conf,
    output logic [CW-1:0] init_q,
    output logic [31:0]   entry_q,
    output logic          load,
    output logic [CW-1:0] load_val
);
    assign load     = wr_en && (addr == REG_INIT);
    assign load_val = wdata[CW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_conf <= '0;
            init_q   <= '0;
            entry_q  <= ENTRY_RESET;
        end else if (wr_en) begin
            unique case (addr)
                REG_DIV:   div_conf <= {wdata[3], 1'b0, wdata[1:0]};
                REG_INIT:  init_q   <= wdata[CW-1:0];
                REG_ENTRY: entry_q  <= (wdata & ~ENTRY_RO) | (entry_q & ENTRY_RO);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
    parameter int PW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] shift,
    output logic       tick
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    assign limit = (PW'(1) << shift) - PW'(1);
    assign tick  = run && !restart && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart || tick) pre_q <= '0;
        else                                   pre_q <= pre_q + PW'(1);
    end
endmodule

// File: rtl/cdt_fsm.sv
module cdt_fsm
    import cdt_pkg::*;
#(
    parameter int CW = 32,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    input  logic          tick,
    input  logic          periodic,
    input  logic          masked,
    input  logic [VW-1:0] vec_in,
    output logic          running,
    output logic [CW-1:0] cur_q,
    output logic          irq_pulse,
    output logic [VW-1:0] irq_vec
);
    cdt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_d;
    logic          expire;

    assign running = (state_q == ST_RUN);
    assign expire  = running && tick && !load && (cur_q == CW'(1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cur_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load && load_val != '0) begin     // arm
                    state_d = ST_RUN;
                    cnt_d   = load_val;
                end
            end
            ST_RUN: begin
                if (load) begin
                    if (load_val == '0) begin         // stop
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin                    // restart
                        cnt_d   = load_val;
                    end
                end else if (tick) begin
                    if (cur_q == CW'(1)) begin
                        if (periodic) cnt_d = reload_val;  // reload
                        else begin                          // expire
                            state_d = ST_IDLE;
                            cnt_d   = '0;
                        end
                    end else begin
                        cnt_d = cur_q - CW'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
            irq_vec   <= '0;
        end else begin
            irq_pulse <= expire && !masked;
            if (expire) irq_vec <= vec_in;
        end
    end
endmodule

// File: rtl/cdtimer.sv
module cdtimer
    import cdt_pkg::*;
#(
    parameter int CW = 32,
    parameter int VW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq_pulse,
    output logic [VW-1:0] irq_vec
);
    logic [3:0]    div_conf;
    logic [CW-1:0] init_q;
    logic [31:0]   entry_q;
    logic          load;
    logic [CW-1:0] load_val;
    logic          tick;
    logic          running;
    logic [CW-1:0] cur_q;

    cdt_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_en && bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .div_conf(div_conf), .init_q(init_q),
        .entry_q(entry_q), .load(load), .load_val(load_val)
    );

    cdt_prescale #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(load),
        .shift(div_shift(div_conf)), .tick(tick)
    );

    cdt_fsm #(.CW(CW), .VW(VW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .reload_val(init_q), .tick(tick),
        .periodic(entry_q[ENTRY_PERIODIC_BIT]), .masked(entry_q[ENTRY_MASK_BIT]),
        .vec_in(entry_q[VW-1:0]), .running(running), .cur_q(cur_q),
        .irq_pulse(irq_pulse), .irq_vec(irq_vec)
    );

    always_comb begin
        unique case (bus_addr)
            REG_DIV:   bus_rdata = {28'd0, div_conf};
            REG_INIT:  bus_rdata = 32'(init_q);
            REG_CUR:   bus_rdata = 32'(cur_q);
            REG_ENTRY: bus_rdata = entry_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          running,
    input logic [CW-1:0] cur,
    input logic          tick,
    input logic          load,
    input logic [31:0]   entry,
    input logic          irq
);
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> cur == '0);

    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load && !tick) |=> $stable(cur));

    assert_pulse_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(cur) == CW'(1) && $past(tick) && !$past(load)));

    assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(entry[16]));

    assert_ro_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(entry[12]) && $stable(entry[14]));
endmodule

bind cdtimer cdt_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .cur(cur_q),
    .tick(tick), .load(load), .entry(entry_q), .irq(irq_pulse)
);

// File: tb/cdtimer_test.sv
module cdtimer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vec;

    int cyc = 0, wr_cyc = 0, n_chk = 0, n_fail = 0;
    int exp_cyc[$];
    int exp_vec[$];

    cdtimer uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse), .irq_vec(irq_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 wr_cyc = cyc;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic expect_irq(input int at, input int vec);
        exp_cyc.push_back(at);
        exp_vec.push_back(vec);
    endtask

    task automatic drained(input string tag);
        check(exp_cyc.size() == 0, tag, exp_cyc.size(), 0);
    endtask

    // scoreboard monitor: each pulse must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && irq_pulse) begin
            if (exp_cyc.size() == 0) begin
                check(1'b0, "R10 unexpected request at cycle", cyc, 0);
            end else begin
                int ec, ev;
                ec = exp_cyc.pop_front();
                ev = exp_vec.pop_front();
                check(cyc == ec, "R2 request cycle", cyc, ec);
                check(int'(irq_vec) == ev, "R10 request vector", irq_vec, ev);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            check(1'b0, "watchdog expired", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); check(rd == 32'h0, "R1 divide reset", rd, 0);
        bus_read(2'd1, rd); check(rd == 32'h0, "R1 start reset", rd, 0);
        bus_read(2'd2, rd); check(rd == 32'h0, "R1 current reset", rd, 0);
        bus_read(2'd3, rd); check(rd == 32'h0001_0000, "R1 entry reset", rd, 32'h0001_0000);
        check(irq_pulse == 1'b0, "R1 no request", irq_pulse, 0);

        // R11 read-only entry bits, R5 idle write to current ignored
        bus_write(2'd3, 32'h0000_5041);
        bus_read(2'd3, rd); check(rd == 32'h0000_0041, "R11 entry ro bits", rd, 32'h41);
        bus_write(2'd2, 32'h55);
        bus_read(2'd2, rd); check(rd == 32'h0, "R5 idle current write ignored", rd, 0);

        // R2/R7 divisor 1 (code 111), one-shot
        bus_write(2'd0, 32'hB);
        bus_write(2'd1, 32'd5);
        expect_irq(wr_cyc + 5, 8'h41);
        bus_read(2'd1, rd); check(rd == 32'd5, "R11 start readback", rd, 5);
        bus_read(2'd2, rd); check(rd == 32'd5, "R4 current after write", rd, 5);
        wait_to(wr_cyc + 15);
        drained("R7 one-shot single request");
        bus_read(2'd2, rd); check(rd == 32'h0, "R7 idle after expiry", rd, 0);

        // R2/R4 divisor 2 (code 000), rounded-up read mid period
        bus_write(2'd0, 32'h0);
        bus_write(2'd1, 32'd4);
        w0 = wr_cyc;
        expect_irq(w0 + 8, 8'h41);
        wait_to(w0 + 3);
        bus_read(2'd2, rd); check(rd == 32'd3, "R4 rounded-up count", rd, 3);
        wait_to(w0 + 12);
        drained("R2 divisor 2");

        // R2 divisor 32 (code 100)
        bus_write(2'd0, 32'h8);
        bus_write(2'd1, 32'd3);
        expect_irq(wr_cyc + 96, 8'h41);
        wait_to(wr_cyc + 100);
        drained("R2 divisor 32");

        // R2 divisor 16 (code 011)
        bus_write(2'd0, 32'h3);
        bus_write(2'd1, 32'd2);
        expect_irq(wr_cyc + 32, 8'h41);
        wait_to(wr_cyc + 36);
        drained("R2 divisor 16");

        // R3 divide keeps bits 3,1,0 -> 0x2, code 010, divisor 8
        bus_write(2'd0, 32'hFFFF_FFF6);
        bus_read(2'd0, rd); check(rd == 32'h2, "R3 divide readback", rd, 2);
        bus_write(2'd1, 32'd2);
        w0 = wr_cyc;
        expect_irq(w0 + 16, 8'h41);
        wait_to(w0 + 9);
        bus_read(2'd2, rd); check(rd == 32'd1, "R4 rounded-up divisor 8", rd, 1);
        wait_to(w0 + 20);
        drained("R3 divisor 8");

        // R8 periodic, then R6 stop with zero
        bus_write(2'd0, 32'hB);
        bus_write(2'd3, 32'h0002_0033);
        bus_write(2'd1, 32'd3);
        w0 = wr_cyc;
        expect_irq(w0 + 3, 8'h33);
        expect_irq(w0 + 6, 8'h33);
        expect_irq(w0 + 9, 8'h33);
        wait_to(w0 + 9);
        bus_write(2'd1, 32'd0);
        wait_to(w0 + 30);
        drained("R8 periodic requests");
        bus_read(2'd2, rd); check(rd == 32'h0, "R6 stopped by zero", rd, 0);

        // R9 masked one-shot still counts; R5 write to current ignored while running
        bus_write(2'd3, 32'h0001_0033);
        bus_write(2'd1, 32'd20);
        w0 = wr_cyc;
        bus_write(2'd2, 32'h7);
        bus_read(2'd2, rd);
        check(rd == 32'(20 - (wr_cyc - w0)), "R5 running current write ignored", rd, 20 - (wr_cyc - w0));
        check(rd < 32'd20, "R9 masked countdown continues", rd, 19);
        wait_to(w0 + 30);
        bus_read(2'd2, rd); check(rd == 32'h0, "R9 masked expiry idle", rd, 0);

        // R4 restart abandons earlier countdown
        bus_write(2'd3, 32'h0000_00A5);
        bus_write(2'd1, 32'd10);
        wait_to(wr_cyc + 3);
        bus_write(2'd1, 32'd4);
        w0 = wr_cyc;
        expect_irq(w0 + 4, 8'hA5);
        wait_to(w0 + 20);
        drained("R4 restart single request");
        bus_read(2'd2, rd); check(rd == 32'h0, "R7 idle after restart expiry", rd, 0);

        finish_run();
    end
endmodule